// File: doc/BRIEF.md
# Nonvolatile Write Busy Gate with Acknowledge Polling

This block sits on the slave side of a two-wire serial port, behind a bit-level shifter that has already decoded the bus into single-cycle events: START, STOP, a received address byte, and a fully received nonvolatile write command. A write command names a target kind (a wiper storage register or a control/status register), a target index and a data word. The block arms such a write only inside a transaction whose address byte matched and asked for a write. It commits the write only when the transaction closes with a STOP.

At that STOP the block sends one commit strobe toward storage and starts a self-timed busy interval that stands for the internal programming cycle. While the interval runs, every address byte is refused, whatever its device field or direction bit. A master therefore finds out that programming has finished by repeating START plus address until the slave acknowledges. A START that arrives before the closing STOP drops the armed write.

The acknowledge decision is registered. It appears one cycle after the address event, together with a qualifier that marks the cycle as carrying a decision.

Top module: `nvw_poll_gate`

## Requirements
- R1: A commit pulse and the rise of `busy_o` both appear in the cycle after a STOP event, and only when that STOP closes a transaction that holds an armed write. No busy interval starts before the STOP.
- R2: `busy_o` stays high for exactly `BUSY_CYC` clock cycles after it rises, then falls by itself.
- R3: While `busy_o` is high, every address byte gets `ack_vld_o`=1 with `ack_o`=0 in the next cycle.
- R4: When the block is not busy, an address byte whose device field (bits 7:1) equals `DEV_ID` gets `ack_vld_o`=1 and `ack_o`=1 in the next cycle.
- R5: The direction bit (bit 0 of the address byte) does not change the acknowledge decision, either while busy or while idle.
- R6: An address byte whose device field differs from `DEV_ID` in any bit selected by `ID_MASK` is never acknowledged.
- R7: A write command is ignored, and no commit follows at the next STOP, in three cases: it arrives while busy, it arrives with no preceding matched address, or it follows an address whose direction bit is 1 (read).
- R8: Both target kinds start the same busy interval. `commit_kind_o` is 0 for a wiper storage register and 1 for a control/status register, and `commit_tgt_o` and `commit_data_o` carry the armed write's index and data.
- R9: A START between an armed write and its STOP cancels the write, so the following STOP produces no commit and no busy interval.
- R10: Asserting `rst_n` low clears `busy_o` at once, without waiting for a clock edge, and also clears the timer.
- R11: `commit_o` is high for exactly one cycle per committed write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| start_i | input | 1 | START event from the shifter |
| stop_i | input | 1 | STOP event from the shifter |
| addr_vld_i | input | 1 | Address byte received |
| addr_byte_i | input | 8 | Address byte: device field in bits 7:1, direction in bit 0 (1 = read) |
| wr_vld_i | input | 1 | Nonvolatile write command received |
| wr_kind_i | input | 1 | Target kind: 0 wiper storage, 1 control/status |
| wr_tgt_i | input | TGT_W | Target index |
| wr_data_i | input | DATA_W | Data to store |
| ack_vld_o | output | 1 | Acknowledge decision valid (one cycle after the address event) |
| ack_o | output | 1 | 1 = acknowledge the address, 0 = leave the line released |
| busy_o | output | 1 | Programming interval in progress |
| commit_o | output | 1 | Single-cycle commit strobe to storage |
| commit_kind_o | output | 1 | Target kind of the committed write |
| commit_tgt_o | output | TGT_W | Target index of the committed write |
| commit_data_o | output | DATA_W | Data of the committed write |

## Verification
Address bytes are sent with both direction bits, both with a matching and with a mismatching device field, and both inside and outside the busy interval. This shows whether the refusal comes from the busy state or from the address compare, and shows that the direction bit plays no part in either. Write sequences cover both target kinds, a clean STOP, a START-aborted sequence, a read-mode selection, a missing address, and a write sent during busy. These separate arming from committing. A reset in the middle of a busy interval, together with a repeated poll until the acknowledge comes back, exercises how the busy interval ends.

// File: rtl/nvw_pkg.sv
`timescale 1ns/1ps
package nvw_pkg;
  localparam int ADDR_BYTE_W = 8;
  localparam int DEV_W       = ADDR_BYTE_W - 1;

  typedef enum logic {
    NVK_WIPER = 1'b0,
    NVK_CTRL  = 1'b1
  } nv_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WSEL  = 2'd1,
    SQ_ARMED = 2'd2
  } seq_st_e;
endpackage

// File: rtl/nvw_rst_sync.sv
`timescale 1ns/1ps
module nvw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/nvw_addr_match.sv
`timescale 1ns/1ps
module nvw_addr_match
  import nvw_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ID  = 7'h2C,
  parameter logic [DEV_W-1:0] ID_MASK = 7'h7F
) (
  input  logic [ADDR_BYTE_W-1:0] addr_byte,
  output logic                   hit
);
  logic [DEV_W-1:0] bit_ok;

  // One comparator per device-field bit; masked-off bits always agree.
  for (genvar i = 0; i < DEV_W; i++) begin : g_bit
    assign bit_ok[i] = ~ID_MASK[i] | (addr_byte[i+1] == DEV_ID[i]);
  end

  assign hit = &bit_ok;
endmodule

// File: rtl/nvw_seq_ctl.sv
`timescale 1ns/1ps
module nvw_seq_ctl
  import nvw_pkg::*;
#(
  parameter int TGT_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              addr_vld,
  input  logic              addr_hit,
  input  logic              addr_rw,
  input  logic              wr_vld,
  input  logic              wr_kind,
  input  logic [TGT_W-1:0]  wr_tgt,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              fire,
  output logic              fire_kind,
  output logic [TGT_W-1:0]  fire_tgt,
  output logic [DATA_W-1:0] fire_data
);
  seq_st_e           state_q, state_d;
  nv_kind_e          kind_q;
  logic [TGT_W-1:0]  tgt_q;
  logic [DATA_W-1:0] data_q;
  logic              cap_en;

  // Next state: START and STOP always close the transaction.
  always_comb begin
    state_d = state_q;
    cap_en  = 1'b0;
    if (start) begin
      state_d = SQ_IDLE;
    end else if (stop) begin
      state_d = SQ_IDLE;
    end else if (addr_vld) begin
      state_d = (addr_hit && !busy && !addr_rw) ? SQ_WSEL : SQ_IDLE;
    end else if (wr_vld && !busy && (state_q != SQ_IDLE)) begin
      state_d = SQ_ARMED;
      cap_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= NVK_WIPER;
      tgt_q  <= '0;
      data_q <= '0;
    end else if (cap_en) begin
      kind_q <= nv_kind_e'(wr_kind);
      tgt_q  <= wr_tgt;
      data_q <= wr_data;
    end
  end

  assign fire      = stop && !start && (state_q == SQ_ARMED) && !busy;
  assign fire_kind = kind_q;
  assign fire_tgt  = tgt_q;
  assign fire_data = data_q;

  // R9: START drops any armed write.
  p_start_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q == SQ_IDLE));

  // R7: nothing can be armed while the programming interval runs.
  p_busy_no_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (state_q != SQ_ARMED)) |=> (state_q != SQ_ARMED));

  // R7: a read-direction address never leads to a write selection.
  p_read_no_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && !start && !stop && addr_rw) |=> (state_q == SQ_IDLE));
endmodule

// File: rtl/nvw_busy_timer.sv
`timescale 1ns/1ps
module nvw_busy_timer #(
  parameter int BUSY_CYC = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CNT_W = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             upd;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  assign upd = load | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  // R1: a load opens the interval with the full count.
  p_load_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && (cnt_q == LOAD_VAL)));

  // R2: the interval holds while count remains and ends when it is spent.
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q != '0) && !load) |=> busy_q);
  p_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && (cnt_q == '0) && !load) |=> !busy_q);

  // R7: no second load while a cycle is running.
  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !load);
endmodule

// File: rtl/nvw_poll_gate.sv
`timescale 1ns/1ps
module nvw_poll_gate
  import nvw_pkg::*;
#(
  parameter logic [DEV_W-1:0] DEV_ID   = 7'h2C,
  parameter logic [DEV_W-1:0] ID_MASK  = 7'h7F,
  parameter int               BUSY_CYC = 1_000_000,
  parameter int               TGT_W    = 2,
  parameter int               DATA_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   addr_vld_i,
  input  logic [ADDR_BYTE_W-1:0] addr_byte_i,
  input  logic                   wr_vld_i,
  input  logic                   wr_kind_i,
  input  logic [TGT_W-1:0]       wr_tgt_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic                   ack_vld_o,
  output logic                   ack_o,
  output logic                   busy_o,
  output logic                   commit_o,
  output logic                   commit_kind_o,
  output logic [TGT_W-1:0]       commit_tgt_o,
  output logic [DATA_W-1:0]      commit_data_o
);
  logic              rst_s_n;
  logic              hit;
  logic              busy;
  logic              fire;
  logic              fire_kind;
  logic [TGT_W-1:0]  fire_tgt;
  logic [DATA_W-1:0] fire_data;

  logic              ack_vld_q, ack_vld_d, ack_q, ack_d;
  logic              com_q, com_d;
  logic              ckind_q;
  logic [TGT_W-1:0]  ctgt_q;
  logic [DATA_W-1:0] cdata_q;

  nvw_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  nvw_addr_match #(.DEV_ID(DEV_ID), .ID_MASK(ID_MASK)) u_match (
    .addr_byte (addr_byte_i),
    .hit       (hit)
  );

  nvw_seq_ctl #(.TGT_W(TGT_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start_i),
    .stop      (stop_i),
    .addr_vld  (addr_vld_i),
    .addr_hit  (hit),
    .addr_rw   (addr_byte_i[0]),
    .wr_vld    (wr_vld_i),
    .wr_kind   (wr_kind_i),
    .wr_tgt    (wr_tgt_i),
    .wr_data   (wr_data_i),
    .busy      (busy),
    .fire      (fire),
    .fire_kind (fire_kind),
    .fire_tgt  (fire_tgt),
    .fire_data (fire_data)
  );

  nvw_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (fire),
    .busy  (busy)
  );

  // Acknowledge decision: device field match and not programming.
  always_comb begin
    ack_vld_d = addr_vld_i;
    ack_d     = addr_vld_i & hit & ~busy;
    com_d     = fire;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ack_vld_q <= 1'b0;
      ack_q     <= 1'b0;
      com_q     <= 1'b0;
    end else begin
      ack_vld_q <= ack_vld_d;
      ack_q     <= ack_d;
      com_q     <= com_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ckind_q <= 1'b0;
      ctgt_q  <= '0;
      cdata_q <= '0;
    end else if (fire) begin
      ckind_q <= fire_kind;
      ctgt_q  <= fire_tgt;
      cdata_q <= fire_data;
    end
  end

  assign ack_vld_o     = ack_vld_q;
  assign ack_o         = ack_q;
  assign busy_o        = busy;
  assign commit_o      = com_q;
  assign commit_kind_o = ckind_q;
  assign commit_tgt_o  = ctgt_q;
  assign commit_data_o = cdata_q;

  // R3: no acknowledge while programming.
  p_busy_nack_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (addr_vld_i && busy) |=> (ack_vld_o && !ack_o));

  // R4: a matching address is acknowledged when idle.
  p_idle_ack_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (addr_vld_i && hit && !busy) |=> (ack_vld_o && ack_o));

  // R5: for a match, only the busy state decides; the direction bit is not involved.
  p_rw_free_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (addr_vld_i && hit) |=> (ack_o == !$past(busy_o)));

  // R6: a mismatching device field is never acknowledged.
  p_miss_nack_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (addr_vld_i && !hit) |=> !ack_o);

  // R1: a commit only follows a STOP and coincides with the start of busy.
  p_fire_on_stop_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    fire |-> stop_i);
  p_commit_busy_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    commit_o |-> $rose(busy_o));

  // R11: the commit strobe lasts one cycle.
  p_commit_pulse_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    commit_o |=> !commit_o);
endmodule

// File: tb/sim_nvw_poll_gate.sv
`timescale 1ns/1ps
module sim_nvw_poll_gate;
  localparam int         BC  = 40;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int         TW  = 2;
  localparam int         DW  = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, stop_i, addr_vld_i, wr_vld_i, wr_kind_i;
  logic [7:0]    addr_byte_i;
  logic [TW-1:0] wr_tgt_i;
  logic [DW-1:0] wr_data_i;
  logic          ack_vld_o, ack_o, busy_o, commit_o, commit_kind_o;
  logic [TW-1:0] commit_tgt_o;
  logic [DW-1:0] commit_data_o;

  always #2.5 clk = ~clk;

  nvw_poll_gate #(.DEV_ID(DEV), .BUSY_CYC(BC), .TGT_W(TW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .addr_vld_i(addr_vld_i), .addr_byte_i(addr_byte_i), .wr_vld_i(wr_vld_i),
    .wr_kind_i(wr_kind_i), .wr_tgt_i(wr_tgt_i), .wr_data_i(wr_data_i),
    .ack_vld_o(ack_vld_o), .ack_o(ack_o), .busy_o(busy_o), .commit_o(commit_o),
    .commit_kind_o(commit_kind_o), .commit_tgt_o(commit_tgt_o),
    .commit_data_o(commit_data_o)
  );

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R10";

  // Behavioural reference model
  int m_left = 0;
  bit m_sel_wr, m_pend, m_kind, wb;
  int m_tgt, m_data;
  bit e_ackv, e_ack, e_commit, e_kind;
  int e_tgt, e_data;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_sel_wr = 0; m_pend = 0; m_kind = 0; m_tgt = 0; m_data = 0;
      e_ackv = 0; e_ack = 0; e_commit = 0; e_kind = 0; e_tgt = 0; e_data = 0;
    end else begin
      wb = (m_left > 0);
      e_ackv = addr_vld_i;
      e_ack = addr_vld_i && (addr_byte_i[7:1] == DEV) && !wb;
      e_commit = 0;
      if (m_left > 0) m_left--;
      if (start_i) begin
        m_sel_wr = 0; m_pend = 0;
      end else if (stop_i) begin
        if (m_pend && !wb) begin
          e_commit = 1; e_kind = m_kind; e_tgt = m_tgt; e_data = m_data; m_left = BC;
        end
        m_sel_wr = 0; m_pend = 0;
      end else if (addr_vld_i) begin
        m_sel_wr = (addr_byte_i[7:1] == DEV) && !wb && !addr_byte_i[0];
        m_pend = 0;
      end else if (wr_vld_i && m_sel_wr && !wb) begin
        m_pend = 1; m_kind = wr_kind_i; m_tgt = int'(wr_tgt_i); m_data = int'(wr_data_i);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(32'(ack_vld_o), rst_n ? 32'(e_ackv) : 0, "ack_vld_o");
      chk(32'(ack_o), rst_n ? 32'(e_ack) : 0, "ack_o");
      chk(32'(busy_o), rst_n ? 32'(m_left > 0) : 0, "busy_o");
      chk(32'(commit_o), rst_n ? 32'(e_commit) : 0, "commit_o");
      chk(32'(commit_kind_o), rst_n ? 32'(e_kind) : 0, "commit_kind_o");
      chk(32'(commit_tgt_o), rst_n ? 32'(e_tgt) : 0, "commit_tgt_o");
      chk(32'(commit_data_o), rst_n ? 32'(e_data) : 0, "commit_data_o");
    end
  end

  task automatic go(input int n = 1);
    repeat (n) begin
      @(posedge clk); #1;
      start_i = 0; stop_i = 0; addr_vld_i = 0; wr_vld_i = 0;
    end
  endtask
  task automatic ev_start(); start_i = 1; go(1); endtask
  task automatic ev_stop();  stop_i = 1;  go(1); endtask
  task automatic ev_addr(input logic [6:0] dev, input logic rw);
    addr_byte_i = {dev, rw}; addr_vld_i = 1; go(1);
  endtask
  task automatic ev_wr(input logic k, input logic [TW-1:0] t, input logic [DW-1:0] d);
    wr_kind_i = k; wr_tgt_i = t; wr_data_i = d; wr_vld_i = 1; go(1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    int t0;
    rst_n = 0; start_i = 0; stop_i = 0; addr_vld_i = 0; wr_vld_i = 0;
    wr_kind_i = 0; wr_tgt_i = '0; wr_data_i = '0; addr_byte_i = '0;
    repeat (4) @(posedge clk);
    #1;
    cur_req = "R10";
    chk(32'(busy_o), 0, "reset busy");
    chk(32'(commit_o), 0, "reset commit");
    rst_n = 1;
    go(4);

    cur_req = "R4";
    ev_start(); ev_addr(DEV, 1'b0);
    chk(32'({ack_vld_o, ack_o}), 3, "match write-dir ack");
    ev_stop();
    cur_req = "R5";
    ev_start(); ev_addr(DEV, 1'b1);
    chk(32'({ack_vld_o, ack_o}), 3, "match read-dir ack");
    ev_stop();
    cur_req = "R6";
    ev_start(); ev_addr(DEV ^ 7'h01, 1'b0);
    chk(32'({ack_vld_o, ack_o}), 2, "low-bit mismatch nack");
    ev_addr(DEV ^ 7'h40, 1'b1);
    chk(32'({ack_vld_o, ack_o}), 2, "high-bit mismatch nack");
    ev_stop();

    cur_req = "R1";
    ev_start(); ev_addr(DEV, 1'b0); ev_wr(1'b0, 2'd1, 8'hA5);
    go(3);
    chk(32'(busy_o), 0, "no busy before STOP");
    ev_stop();
    t0 = cyc;
    chk(32'(commit_o), 1, "commit after STOP");
    chk(32'(busy_o), 1, "busy after STOP");
    cur_req = "R8";
    chk(32'({commit_kind_o, commit_tgt_o, commit_data_o}), 32'({1'b0, 2'd1, 8'hA5}), "wiper commit fields");
    go(1);
    cur_req = "R11";
    chk(32'(commit_o), 0, "commit one cycle");

    cur_req = "R3";
    ev_start(); ev_addr(DEV, 1'b0);
    chk(32'({ack_vld_o, ack_o}), 2, "busy nack write-dir");
    ev_stop(); ev_start(); ev_addr(DEV, 1'b1);
    cur_req = "R5";
    chk(32'({ack_vld_o, ack_o}), 2, "busy nack read-dir");
    ev_stop();
    cur_req = "R7";
    ev_start(); ev_addr(DEV, 1'b0); ev_wr(1'b1, 2'd2, 8'h3C); ev_stop();
    chk(32'(commit_o), 0, "write during busy ignored");

    cur_req = "R2";
    while (busy_o) go(1);
    chk(32'(cyc - t0), BC, "busy length");
    cur_req = "R4";
    ev_start(); ev_addr(DEV, 1'b1);
    chk(32'({ack_vld_o, ack_o}), 3, "poll acked after busy");
    ev_stop();
    go(2);

    cur_req = "R8";
    ev_start(); ev_addr(DEV, 1'b0); ev_wr(1'b1, 2'd3, 8'h5A); ev_stop();
    chk(32'({commit_o, busy_o}), 3, "ctrl write starts busy");
    chk(32'({commit_kind_o, commit_tgt_o, commit_data_o}), 32'({1'b1, 2'd3, 8'h5A}), "ctrl commit fields");
    cur_req = "R2";
    while (busy_o) go(1);
    go(2);

    cur_req = "R9";
    ev_start(); ev_addr(DEV, 1'b0); ev_wr(1'b0, 2'd0, 8'h11); ev_start(); ev_stop();
    chk(32'({commit_o, busy_o}), 0, "START abort");
    cur_req = "R7";
    ev_start(); ev_addr(DEV, 1'b1); ev_wr(1'b0, 2'd2, 8'h22); ev_stop();
    chk(32'({commit_o, busy_o}), 0, "read-dir selection no commit");
    ev_start(); ev_wr(1'b1, 2'd1, 8'h33); ev_stop();
    chk(32'({commit_o, busy_o}), 0, "write without address no commit");
    go(2);

    cur_req = "R10";
    ev_start(); ev_addr(DEV, 1'b0); ev_wr(1'b0, 2'd1, 8'h77); ev_stop();
    chk(32'(busy_o), 1, "busy before reset");
    go(3);
    rst_n = 0;
    #0.5;
    chk(32'(busy_o), 0, "busy cleared at once by reset");
    go(2);
    rst_n = 1;
    go(5);
    chk(32'(busy_o), 0, "busy stays clear after reset");
    ev_start(); ev_addr(DEV, 1'b0);
    chk(32'({ack_vld_o, ack_o}), 3, "ack after reset");
    ev_stop();
    go(2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule